// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block lets a host read and write the 16-bit management registers of external Ethernet PHYs over a two-wire management bus. The host sees eight byte-wide registers. The first four form a 32-bit command word and the last four form a 32-bit status word. Byte 0 of each word is the least significant byte.

The host first writes the low command bytes. It then writes the top command byte with its start bit set, which launches one 64-bit management frame. The block derives the management clock from the system clock and shifts the frame out. For reads, it releases the data line at the turnaround and shifts in the PHY's answer. The start bit reads as 1 for the length of the frame, and the host polls it. When the frame ends, the start bit clears, the read value sits in status bits 15:0, and status bit 31 is set if no PHY answered.

Top module: `mdio_master`

## Requirements
- R1: After reset, all eight byte registers read 0x00, `mdc` is low and `mdio_oe` is low.
- R2: Addresses 0..3 return command bytes 0..3 and addresses 4..7 return status bytes 0..3. While idle, command bytes written at 0..3 read back unchanged, except that command bit 31 (bit 7 of address 3) always reads the busy state.
- R3: A write to address 3 with data bit 7 set while idle launches a frame, and command bit 31 then reads 1 for exactly 128*DIV_HALF clock cycles. Writes to addresses 0..2, and writes to address 3 with bit 7 clear, launch nothing.
- R4: Command bit 26 selects a write (1) or a read (0). Bits 25:21 are the PHY address, bits 20:16 are the register address and bits 15:0 are the write data.
- R5: A frame is 64 `mdc` periods. In order it carries 32 ones, the start pattern 01, the opcode (10 for a read, 01 for a write), the PHY address, the register address, the turnaround and 16 data bits, each field MSB first. A write drives the turnaround as 10.
- R6: `mdc` high and low phases each last DIV_HALF clock cycles. While driven, `mdio_o` changes only in a cycle where `mdc` is low, and `mdio_i` is sampled as `mdc` rises.
- R7: In a read, `mdio_oe` is low from the first turnaround bit to the end of the frame. If `mdio_i` is high at the second turnaround bit, status bit 31 is set. An unanswered read on a pulled-up line therefore leaves status 0x8000_FFFF.
- R8: Launching any frame clears the status word to zero. When a read ends, status bits 15:0 hold the 16 bits sampled in the data field and bits 30:16 are zero. A write leaves the status word at zero.
- R9: Writes to command bytes while a frame runs are ignored, and a second start request during a frame launches nothing. Writes to addresses 4..7 are always ignored.
- R10: Whenever no frame runs, `mdc` is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| addr | input | 3 | Host byte address (0..3 command, 4..7 status) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for `addr` (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data value to drive on the management line |
| mdio_oe | output | 1 | Drive enable for the management line (0 = released) |
| mdio_i | input | 1 | Sensed level of the management line |

## Verification
A wrong bit counter or phase flag shows up first on the bus. The PHY model captures a frame that is shifted, truncated or too long, and this is visible within one frame of 64 `mdc` periods. It also shows as a busy time that differs from 128*DIV_HALF cycles, which the host's polling detects when the frame ends. A fault in the turnaround or sampling path appears only in read frames: the line is driven by both ends, the fail flag is wrong, or the status data is wrong, all readable as soon as the start bit clears. A fault in the register file shows immediately in byte read-back: a stray launch, lost bytes, or a status word that is not cleared at launch.

// File: rtl/mdio_pkg.sv
// Shared constants for the management master: frame geometry,
// command word field positions and the serializer state type.
package mdio_pkg;
    localparam int FRAME_LEN = 64;   // management clock periods per frame
    localparam int PRE_LEN   = 32;   // leading ones
    localparam int TA1_IDX   = 46;   // first turnaround bit
    localparam int TA2_IDX   = 47;   // second turnaround bit (PHY drives 0)
    localparam int DATA_IDX  = 48;   // first data bit
    localparam int IDX_W     = $clog2(FRAME_LEN);

    localparam int CMD_START = 31;
    localparam int CMD_WR    = 26;
    localparam int CMD_PHY_L = 21;
    localparam int CMD_REG_L = 16;

    typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_t;
endpackage

// File: rtl/mdio_tick.sv
// Phase timer: while enabled, pulses tick once every HALF cycles.
// Each tick ends one half period of the management clock.
// Assumes HALF >= 1; the counter restarts whenever en is low.
module mdio_tick #(
    parameter int HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    // Tick at the last count of each half period.
    assign tick = en && (cnt_q == CW'(HALF - 1));

    // Count cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!en || tick)  cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mdio_engine.sv
// Frame serializer/deserializer. On launch it loads a 64-bit frame and,
// at each phase tick, alternately raises mdc (sampling mdio_i) and lowers
// mdc (shifting the next bit out). For reads it releases the line from the
// first turnaround bit on, checks the PHY pulls the second turnaround
// bit low, and collects 16 data bits. Assumes launch arrives only when idle.
module mdio_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  logic        l_wr,
    input  logic [4:0]  l_phy,
    input  logic [4:0]  l_reg,
    input  logic [15:0] l_data,
    input  logic        tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        rd_done,
    output logic [15:0] rd_data,
    output logic        rd_fail
);
    eng_state_t           state_q;
    logic                 is_wr_q;
    logic [FRAME_LEN-1:0] sreg_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 high_q;
    logic                 mdc_q;
    logic                 oe_q;
    logic                 done_q;
    logic [15:0]          rx_q;
    logic                 fail_q;
    logic [FRAME_LEN-1:0] frame;

    // Assemble the outgoing frame from the launched command fields.
    always_comb begin
        frame = {{PRE_LEN{1'b1}}, 2'b01, (l_wr ? 2'b01 : 2'b10),
                 l_phy, l_reg, 2'b10, (l_wr ? l_data : 16'hFFFF)};
    end

    // Sequence the frame one half period at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            is_wr_q <= 1'b0;
            sreg_q  <= '0;
            idx_q   <= '0;
            high_q  <= 1'b0;
            mdc_q   <= 1'b0;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
            rx_q    <= '0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (launch) begin
                    state_q <= ST_SHIFT;
                    is_wr_q <= l_wr;
                    sreg_q  <= frame;
                    idx_q   <= '0;
                    high_q  <= 1'b0;
                    mdc_q   <= 1'b0;
                    oe_q    <= 1'b1;
                    rx_q    <= '0;
                    fail_q  <= 1'b0;
                end
            end else if (tick) begin
                if (!high_q) begin
                    mdc_q  <= 1'b1;
                    high_q <= 1'b1;
                    if (!is_wr_q) begin
                        if (idx_q == IDX_W'(TA2_IDX))
                            fail_q <= mdio_i;
                        if (idx_q >= IDX_W'(DATA_IDX))
                            rx_q <= {rx_q[14:0], mdio_i};
                    end
                end else if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
                    state_q <= ST_IDLE;
                    mdc_q   <= 1'b0;
                    high_q  <= 1'b0;
                    oe_q    <= 1'b0;
                    done_q  <= !is_wr_q;
                end else begin
                    idx_q  <= idx_q + 1'b1;
                    mdc_q  <= 1'b0;
                    high_q <= 1'b0;
                    sreg_q <= {sreg_q[FRAME_LEN-2:0], 1'b1};
                    oe_q   <= is_wr_q || (idx_q < IDX_W'(TA1_IDX - 1));
                end
            end
        end
    end

    assign busy    = (state_q == ST_SHIFT);
    assign mdc     = mdc_q;
    assign mdio_o  = sreg_q[FRAME_LEN-1];
    assign mdio_oe = oe_q;
    assign rd_done = done_q;
    assign rd_data = rx_q;
    assign rd_fail = fail_q;
endmodule

// File: rtl/mdio_regs.sv
// Host register file: byte-wide access to the command word (0..3) and the
// status word (4..7). Command bytes are writable only while idle. The start
// request is taken from bit 7 of byte 3. The status word clears at launch
// and is loaded when a read ends. Assumes one host access per cycle.
module mdio_regs
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        busy,
    input  logic        rd_done,
    input  logic [15:0] rd_data,
    input  logic        rd_fail,
    output logic [30:0] cmd_q,
    output logic        launch,
    output logic        l_wr,
    output logic [4:0]  l_phy,
    output logic [4:0]  l_reg,
    output logic [15:0] l_data
);
    logic        cmd_wr_ok;
    logic [31:0] status_q;
    logic [31:0] rd_word;
    logic [30:0] cmd_next;

    assign cmd_wr_ok = wr_en && !busy && !addr[2];
    assign launch    = cmd_wr_ok && (addr[1:0] == 2'd3) && wdata[7];

    // Lower three command bytes, one lane each.
    for (genvar b = 0; b < 3; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmd_q[8*b +: 8] <= '0;
            else if (cmd_wr_ok && (addr[1:0] == 2'(b)))
                cmd_q[8*b +: 8] <= wdata;
        end
    end

    // Top command byte without the start bit (that bit reads busy).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q[30:24] <= '0;
        else if (cmd_wr_ok && (addr[1:0] == 2'd3))
            cmd_q[30:24] <= wdata[6:0];
    end

    // Fields of the word being launched (top byte comes from this write).
    assign cmd_next = {wdata[6:0], cmd_q[23:0]};
    assign l_wr     = cmd_next[CMD_WR];
    assign l_phy    = cmd_next[CMD_PHY_L +: 5];
    assign l_reg    = cmd_next[CMD_REG_L +: 5];
    assign l_data   = cmd_next[15:0];

    // Status word: cleared at launch, loaded when a read frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= '0;
        else if (launch)  status_q <= '0;
        else if (rd_done) status_q <= {rd_fail, 15'd0, rd_data};
    end

    // Byte read mux.
    always_comb begin
        rd_word = addr[2] ? status_q : {busy, cmd_q};
        rdata   = rd_word[{addr[1:0], 3'b000} +: 8];
    end
endmodule

// File: rtl/mdio_master.sv
// Top of the management master: register file, phase timer and frame
// engine. The management line is split into drive value, drive enable and
// sensed level; an external pull-up holds it high while released.
// DIV_HALF is the number of system clocks per mdc half period.
module mdio_master #(
    parameter int DIV_HALF = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic       mdio_i
);
    logic        busy;
    logic        tick;
    logic        launch;
    logic        l_wr;
    logic [4:0]  l_phy;
    logic [4:0]  l_reg;
    logic [15:0] l_data;
    logic        rd_done;
    logic [15:0] rd_data;
    logic        rd_fail;
    logic [30:0] cmd_q;

    mdio_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .rd_done(rd_done),
        .rd_data(rd_data), .rd_fail(rd_fail), .cmd_q(cmd_q),
        .launch(launch), .l_wr(l_wr), .l_phy(l_phy), .l_reg(l_reg),
        .l_data(l_data)
    );

    mdio_tick #(.HALF(DIV_HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
    );

    mdio_engine u_eng (
        .clk(clk), .rst_n(rst_n), .launch(launch), .l_wr(l_wr),
        .l_phy(l_phy), .l_reg(l_reg), .l_data(l_data), .tick(tick),
        .mdio_i(mdio_i), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .rd_done(rd_done), .rd_data(rd_data),
        .rd_fail(rd_fail)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Protocol checker for mdio_master, bound into every instance.
module mdio_master_chk #(
    parameter int DIV_HALF = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  addr,
    input logic [7:0]  wdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic [30:0] cmd_q
);
    int unsigned hi_cnt;

    // Length of the current mdc high phase.
    always_ff @(posedge clk) begin
        if (!rst_n)   hi_cnt <= 0;
        else if (mdc) hi_cnt <= hi_cnt + 1;
        else          hi_cnt <= 0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));                                  // R10
    AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc); // R6
    AST_MDC_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= DIV_HALF);                                            // R6
    AST_START_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3 && wdata[7] && !busy) |=> busy);         // R3
    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_q));                      // R9
endmodule

bind mdio_master mdio_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .cmd_q(cmd_q)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int BUSY_LEN   = 128 * HALF;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] val;
        logic        here;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1'b1, 5'd1,  5'd0,  16'h1234, 1'b1},
        '{1'b0, 5'd1,  5'd2,  16'h0141, 1'b1},
        '{1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b1},
        '{1'b0, 5'd0,  5'd1,  16'h796D, 1'b1},
        '{1'b0, 5'd5,  5'd3,  16'hBEEF, 1'b0},
        '{1'b0, 5'd31, 5'd31, 16'h0000, 1'b1},
        '{1'b1, 5'd0,  5'd0,  16'h0000, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // PHY model state
    logic        clr_req = 1'b0;
    int          rise_cnt;
    logic [63:0] cap;
    logic        conflict;
    logic        phy_on = 1'b0;
    logic [4:0]  phy_here = '0;
    logic [15:0] phy_data = '0;
    logic        phy_drv = 1'b0;
    logic        phy_val = 1'b1;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    mdio_master #(.DIV_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model: captures each bit on the rising mdc edge.
    always @(posedge mdc or posedge clr_req) begin
        if (clr_req) begin
            rise_cnt <= 0;
            cap      <= '0;
            conflict <= 1'b0;
        end else begin
            if (rise_cnt < 64) cap[63 - rise_cnt] <= mdio_i;
            if (rise_cnt >= 46 && rise_cnt < 64 && cap[29] && !cap[28] && mdio_oe)
                conflict <= 1'b1;
            rise_cnt <= rise_cnt + 1;
        end
    end

    // PHY model: answers addressed reads after the falling mdc edge.
    always @(negedge mdc) begin
        phy_drv = 1'b0;
        phy_val = 1'b1;
        if (phy_on && cap[29] && !cap[28] && cap[27:23] == phy_here) begin
            if (rise_cnt == 47) begin
                phy_drv = 1'b1; phy_val = 1'b0;
            end else if (rise_cnt >= 48 && rise_cnt < 64) begin
                phy_drv = 1'b1; phy_val = phy_data[63 - rise_cnt];
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            summary();
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic rd_word(input logic [2:0] base, output logic [31:0] w);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(base + 3'(i), b);
            w[8*i +: 8] = b;
        end
    endtask

    task automatic clear_phy();
        @(negedge clk); clr_req = 1'b1; #1; clr_req = 1'b0;
    endtask

    task automatic launch(input logic w, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d);
        logic [31:0] c;
        c = {1'b1, 4'b0, w, p, r, d};
        wr(3'd0, c[7:0]);
        wr(3'd1, c[15:8]);
        wr(3'd2, c[23:16]);
        wr(3'd3, c[31:24]);
    endtask

    // Counts cycles (at negedge) that the start bit reads 1.
    task automatic wait_idle(output int n);
        logic [7:0] b;
        n = 0;
        addr = 3'd3; #1; b = rdata;
        while (b[7] && n < 5000) begin
            n++;
            @(negedge clk); addr = 3'd3; #1; b = rdata;
        end
    endtask

    function automatic logic [63:0] exp_frame(input vec_t v);
        logic [1:0]  ta;
        logic [15:0] dt;
        if (v.wr)        begin ta = 2'b10; dt = v.val;    end
        else if (v.here) begin ta = 2'b10; dt = v.val;    end
        else             begin ta = 2'b11; dt = 16'hFFFF; end
        return {32'hFFFF_FFFF, 2'b01, (v.wr ? 2'b01 : 2'b10), v.phy, v.rg, ta, dt};
    endfunction

    initial begin
        logic [7:0]  b;
        logic [31:0] w;
        int          n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_phy();

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), b);
            check(b == 8'h00, "R1 reset byte", 64'(b), 64'h0);
        end
        check(!mdc && !mdio_oe, "R1 reset bus", {mdc, mdio_oe}, 64'h0);

        // R2/R3: byte map read-back, no launch without start bit
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33); wr(3'd3, 8'h44);
        wr(3'd3, 8'h44);
        rd_word(3'd0, w);
        check(w == 32'h4433_2211, "R2 command read-back", 64'(w), 64'h44332211);
        rd_word(3'd4, w);
        check(w == 32'h0, "R2 status bytes idle", 64'(w), 64'h0);
        repeat (40) @(negedge clk);
        check(rise_cnt == 0, "R3 no launch without start bit", 64'(rise_cnt), 64'h0);

        // Table walk: R3 R4 R5 R7 R8 R10
        foreach (VEC[i]) begin
            phy_on = VEC[i].here; phy_here = VEC[i].phy; phy_data = VEC[i].val;
            clear_phy();
            launch(VEC[i].wr, VEC[i].phy, VEC[i].rg, VEC[i].wr ? VEC[i].val : 16'h0);
            wait_idle(n);
            check(n == BUSY_LEN, "R3 busy length", 64'(n), 64'(BUSY_LEN));
            check(rise_cnt == 64, "R5 mdc periods", 64'(rise_cnt), 64'd64);
            check(cap == exp_frame(VEC[i]), "R4 R5 frame bits", cap, exp_frame(VEC[i]));
            rd_word(3'd4, w);
            if (VEC[i].wr)
                check(w == 32'h0, "R8 status after write", 64'(w), 64'h0);
            else if (VEC[i].here)
                check(w == {16'h0, VEC[i].val}, "R8 read data", 64'(w), 64'(VEC[i].val));
            else
                check(w == 32'h8000_FFFF, "R7 read fail flag", 64'(w), 64'h8000FFFF);
            check(!VEC[i].wr ? !conflict : 1'b1, "R7 line released in read", 64'(conflict), 64'h0);
            check(!mdc && !mdio_oe, "R10 idle after frame", {mdc, mdio_oe}, 64'h0);
        end

        // R8: status cleared at launch (previous status is 0x0000 from last write; set fail first)
        phy_on = 1'b0; clear_phy();
        launch(1'b0, 5'd9, 5'd1, 16'h0);
        wait_idle(n);
        clear_phy();
        launch(1'b1, 5'd9, 5'd1, 16'hA5A5);
        repeat (5) @(negedge clk);
        rd_word(3'd4, w);
        check(w == 32'h0, "R8 status cleared at launch", 64'(w), 64'h0);
        wait_idle(n);

        // R9: command writes and second start ignored while busy
        phy_on = 1'b1; phy_here = 5'd1; phy_data = 16'h5A5A;
        clear_phy();
        launch(1'b0, 5'd1, 5'd2, 16'h0);
        repeat (30) @(negedge clk);
        wr(3'd0, 8'hAA);
        wr(3'd3, 8'hC0);
        wait_idle(n);
        repeat (60) @(negedge clk);
        check(rise_cnt == 64, "R9 no relaunch while busy", 64'(rise_cnt), 64'd64);
        rd(3'd0, b);
        check(b == 8'h00, "R9 byte0 write ignored while busy", 64'(b), 64'h0);
        rd(3'd3, b);
        check(b == 8'h00, "R9 byte3 write ignored while busy", 64'(b), 64'h0);

        // R9: status bytes are read-only
        wr(3'd4, 8'h00); wr(3'd7, 8'hFF);
        rd_word(3'd4, w);
        check(w == 32'h0000_5A5A, "R9 status write ignored", 64'(w), 64'h00005A5A);

        summary();
    end
endmodule